// File: doc/BRIEF.md
# Run-ahead chained exit predictor

This block predicts where control flow leaves each chain of code fragments. Fragments are the stretches of code between possible transfers. Every taken transfer gets its own entry, whether it is conditional or unconditional and whether its target is static or dynamic. A taken call in the middle of a block adds an entry of its own. Each entry stores its target in compressed form: a signed offset from the entry's own key address, plus the number of fragments up to the exit. The fetch unit therefore never needs a separate target buffer and never inspects fetched code to find a target.

Given a seed address, the block walks its own table and needs no help from fetch or decode. The predicted target of one entry becomes the lookup key for the next. Each step sends out a prefetch request on a valid/ready stream. Requests go out back to back, one per cycle, while the consumer is ready and run-ahead credit remains. The walk ends when it looks up an address the table does not hold, and the block then raises a no-prediction flag. A redirect, which reports a misprediction, abandons the walk and restarts it from the corrected address. A seed does the same.

Stream rules for the prefetch output: a request is held with stable address and count until `pf_ready` is sampled high. A flush, meaning a redirect or a seed, is the only exception: it withdraws any pending request in the next cycle. Up to `DEPTH` requests may be issued and not yet consumed. The fetch unit returns credit by pulsing `pf_consume`, one fragment chain per pulse.

Top module: `exitpred_runahead`

## Requirements
- R1: After reset, `pf_valid` and `no_pred` are low and no request is issued until a seed or redirect arrives.
- R2: An update with key K, target T and count F records an entry. When the walk later looks up K, it issues a request with `pf_addr` = T and `pf_frags` = F.
- R3: An update is not recorded when T − K, taken as a signed ADDR_W value, lies outside −2^(OFF_W−1) … 2^(OFF_W−1)−1, which is −128 … 127 by default. Looking up K then ends the walk with no request.
- R4: The target of each issued request becomes the next lookup key. With `pf_ready` high, successive requests appear in consecutive cycles. The first request appears in the second cycle after the seed is sampled.
- R5: When a lookup finds no entry whose tag matches, the walk stops. `no_pred` then goes high with `pf_valid` low, and both stay so until the next seed or redirect.
- R6: No more than DEPTH (default 4) issued requests are left unconsumed. Each `pf_consume` pulse frees one slot, and a pulse when none is outstanding is ignored.
- R7: While `pf_valid` is high and `pf_ready` is low, with no flush, the request stays valid and its address and count do not change.
- R8: A redirect drops any pending request in the next cycle, clears the outstanding count and restarts the walk at `redirect_addr`. A seed does the same at `seed_addr`, and a redirect wins when both are present.
- R9: An update is written into the table one cycle after it is presented. A lookup in that cycle with the same index receives the new entry, so a seed presented together with the update of its own key hits.
- R10: The table is direct-mapped on the low IDX_W key bits, with the remaining bits stored as a tag. An update to a key with the same index and a different tag replaces the older entry, and the older key then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_valid | input | 1 | Start a walk at `seed_addr` |
| seed_addr | input | ADDR_W | Start key of the walk |
| redirect_valid | input | 1 | Misprediction: restart the walk at `redirect_addr` |
| redirect_addr | input | ADDR_W | Corrected address |
| upd_valid | input | 1 | Resolved exit report |
| upd_key | input | ADDR_W | Start address of the resolved chain |
| upd_target | input | ADDR_W | Resolved target of its taken exit |
| upd_frags | input | CNT_W | Fragments up to the exit |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Consumer accepts the request |
| pf_addr | output | ADDR_W | Predicted next chain address to prefetch |
| pf_frags | output | CNT_W | Fragment count of the predicted exit |
| pf_consume | input | 1 | One outstanding request has been used |
| no_pred | output | 1 | Walk ended on a table miss |

## Verification
The assertions check four rules on every cycle: a stalled request is held, the outstanding count never exceeds DEPTH, a flush empties the output, and a miss leaves the output quiet. They also check that a staged update lands in its table slot. Only the bench scenarios can show the rest. Those are the values of the walked chain, including negative offsets, and that its requests leave back to back. They also cover out-of-range targets being dropped, credit being returned by a consume, forwarding of an update to a seed that arrives with it, and aliasing within the direct-mapped table.

// File: rtl/exitpred_pkg.sv
package exitpred_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_MISS = 2'd2
  } walk_state_e;
endpackage

// File: rtl/exitpred_table.sv
module exitpred_table #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_key,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [CNT_W-1:0]  upd_frags,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic [CNT_W-1:0]  lk_frags
);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic signed [ADDR_W-1:0] OFF_MAX = ADDR_W'((1 << (OFF_W-1)) - 1);
  localparam logic signed [ADDR_W-1:0] OFF_MIN = ~OFF_MAX;

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  logic [OFF_W-1:0] off_q   [ENTRIES];
  logic [CNT_W-1:0] frags_q [ENTRIES];

  // staged write, one cycle behind the update port
  logic             st_valid;
  logic [IDX_W-1:0] st_idx;
  logic [TAG_W-1:0] st_tag;
  logic [OFF_W-1:0] st_off;
  logic [CNT_W-1:0] st_frags;

  logic signed [ADDR_W-1:0] diff;
  logic                     in_range;

  always_comb begin
    diff     = $signed(upd_target - upd_key);
    in_range = (diff >= OFF_MIN) && (diff <= OFF_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
    end else begin
      st_valid <= upd_valid && in_range;
    end
    st_idx   <= upd_key[IDX_W-1:0];
    st_tag   <= upd_key[ADDR_W-1:IDX_W];
    st_off   <= diff[OFF_W-1:0];
    st_frags <= upd_frags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (st_valid) begin
      valid_q[st_idx] <= 1'b1;
    end
    if (st_valid) begin
      tag_q[st_idx]   <= st_tag;
      off_q[st_idx]   <= st_off;
      frags_q[st_idx] <= st_frags;
    end
  end

  // lookup with forwarding from the staged write
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             fwd;
  logic             sel_valid;
  logic [TAG_W-1:0] sel_tag;
  logic [OFF_W-1:0] sel_off;

  always_comb begin
    lk_idx    = lk_addr[IDX_W-1:0];
    lk_tag    = lk_addr[ADDR_W-1:IDX_W];
    fwd       = st_valid && (st_idx == lk_idx);
    sel_valid = fwd ? 1'b1     : valid_q[lk_idx];
    sel_tag   = fwd ? st_tag   : tag_q[lk_idx];
    sel_off   = fwd ? st_off   : off_q[lk_idx];
    lk_frags  = fwd ? st_frags : frags_q[lk_idx];
    lk_hit    = sel_valid && (sel_tag == lk_tag);
    lk_target = lk_addr + {{(ADDR_W-OFF_W){sel_off[OFF_W-1]}}, sel_off};
  end

  AST_STAGED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> valid_q[$past(st_idx)]); // R9

endmodule

// File: rtl/exitpred_walker.sv
module exitpred_walker
  import exitpred_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_valid,
  input  logic [ADDR_W-1:0] seed_addr,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic [ADDR_W-1:0] lk_target,
  input  logic [CNT_W-1:0]  lk_frags,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [CNT_W-1:0]  pf_frags,
  input  logic              pf_consume,
  output logic              no_pred
);
  localparam int CRED_W = $clog2(DEPTH + 1);
  localparam logic [CRED_W-1:0] DEPTH_C = CRED_W'(DEPTH);

  walk_state_e       state;
  logic [ADDR_W-1:0] cur;
  logic [CRED_W-1:0] cred;

  logic              flush, slot_free, room, attempt, issue, miss, give_back;
  logic [ADDR_W-1:0] start_addr;

  always_comb begin
    flush      = redir_valid || seed_valid;
    start_addr = redir_valid ? redir_addr : seed_addr;
    slot_free  = !pf_valid || pf_ready;
    room       = cred < DEPTH_C;
    attempt    = (state == WALK_RUN) && slot_free && room;
    issue      = attempt && lk_hit;
    miss       = attempt && !lk_hit;
    give_back  = pf_consume && (cred != '0);
    lk_addr    = cur;
    no_pred    = (state == WALK_MISS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WALK_IDLE;
      cur      <= '0;
      cred     <= '0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
      pf_frags <= '0;
    end else if (flush) begin
      state    <= WALK_RUN;
      cur      <= start_addr;
      cred     <= '0;
      pf_valid <= 1'b0;
    end else begin
      cred <= cred + CRED_W'(issue) - CRED_W'(give_back);
      if (issue) begin
        pf_valid <= 1'b1;
        pf_addr  <= lk_target;
        pf_frags <= lk_frags;
        cur      <= lk_target;
      end else if (slot_free) begin
        pf_valid <= 1'b0;
      end
      if (miss) state <= WALK_MISS;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !flush) |=> (pf_valid && $stable(pf_addr) && $stable(pf_frags))); // R7
  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cred <= DEPTH_C); // R6
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pf_valid); // R8
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    no_pred |-> !pf_valid); // R5

endmodule

// File: rtl/exitpred_runahead.sv
module exitpred_runahead #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 8,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_valid,
  input  logic [ADDR_W-1:0] seed_addr,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_key,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [CNT_W-1:0]  upd_frags,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [CNT_W-1:0]  pf_frags,
  input  logic              pf_consume,
  output logic              no_pred
);
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic [ADDR_W-1:0] lk_target;
  logic [CNT_W-1:0]  lk_frags;

  exitpred_table #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_key    (upd_key),
    .upd_target (upd_target),
    .upd_frags  (upd_frags),
    .lk_addr    (lk_addr),
    .lk_hit     (lk_hit),
    .lk_target  (lk_target),
    .lk_frags   (lk_frags)
  );

  exitpred_walker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_valid  (seed_valid),
    .seed_addr   (seed_addr),
    .redir_valid (redirect_valid),
    .redir_addr  (redirect_addr),
    .lk_addr     (lk_addr),
    .lk_hit      (lk_hit),
    .lk_target   (lk_target),
    .lk_frags    (lk_frags),
    .pf_valid    (pf_valid),
    .pf_ready    (pf_ready),
    .pf_addr     (pf_addr),
    .pf_frags    (pf_frags),
    .pf_consume  (pf_consume),
    .no_pred     (no_pred)
  );

endmodule

// File: tb/tb_exitpred_runahead.sv
module tb_exitpred_runahead;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              seed_valid = 1'b0;
  logic [ADDR_W-1:0] seed_addr = '0;
  logic              redirect_valid = 1'b0;
  logic [ADDR_W-1:0] redirect_addr = '0;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_key = '0;
  logic [ADDR_W-1:0] upd_target = '0;
  logic [CNT_W-1:0]  upd_frags = '0;
  logic              pf_valid;
  logic              pf_ready = 1'b1;
  logic [ADDR_W-1:0] pf_addr;
  logic [CNT_W-1:0]  pf_frags;
  logic              pf_consume = 1'b0;
  logic              no_pred;

  always #10 clk = ~clk; // 50 MHz

  exitpred_runahead dut (
    .clk(clk), .rst_n(rst_n),
    .seed_valid(seed_valid), .seed_addr(seed_addr),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .upd_valid(upd_valid), .upd_key(upd_key), .upd_target(upd_target), .upd_frags(upd_frags),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_frags(pf_frags),
    .pf_consume(pf_consume), .no_pred(no_pred)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int hs_cnt   = 0;
  int hs_first = 0;
  int hs_last  = 0;
  bit done     = 0;
  logic [ADDR_W+CNT_W-1:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_pf(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] f);
    exp_q.push_back({a, f});
  endtask

  // monitor: pops expected requests at each accepted handshake
  always @(negedge clk) begin
    if (rst_n && pf_valid === 1'b1 && pf_ready) begin
      if (hs_cnt == 0) hs_first = cyc;
      hs_last = cyc;
      hs_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected request", {13'd0, pf_addr, pf_frags}, 32'd0);
      end else begin
        logic [ADDR_W+CNT_W-1:0] e;
        e = exp_q.pop_front();
        check({pf_addr, pf_frags} == e, "R2 request addr/frags", {13'd0, pf_addr, pf_frags}, {13'd0, e});
      end
    end
  end

  task automatic do_update(input logic [ADDR_W-1:0] k, input logic [ADDR_W-1:0] t, input logic [CNT_W-1:0] f);
    @(posedge clk); #1;
    upd_valid = 1; upd_key = k; upd_target = t; upd_frags = f;
    @(posedge clk); #1;
    upd_valid = 0;
  endtask

  task automatic do_seed(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    hs_cnt = 0;
    seed_valid = 1; seed_addr = a;
    @(posedge clk); #1;
    seed_valid = 0;
  endtask

  task automatic do_redirect(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    hs_cnt = 0;
    redirect_valid = 1; redirect_addr = a;
    @(posedge clk); #1;
    redirect_valid = 0;
  endtask

  task automatic do_consume();
    @(posedge clk); #1;
    pf_consume = 1;
    @(posedge clk); #1;
    pf_consume = 0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    wait_neg(2);
    // R1: reset state
    check(pf_valid == 0, "R1 pf_valid after reset", {31'd0, pf_valid}, 0);
    check(no_pred == 0, "R1 no_pred after reset", {31'd0, no_pred}, 0);

    // chain A->B->C->D, D unknown (indices 1,3,5,7)
    do_update(16'h0101, 16'h0153, 3'd2);
    do_update(16'h0153, 16'h0125, 3'd1);   // negative offset
    do_update(16'h0125, 16'h0197, 3'd3);
    do_update(16'h0109, 16'h0189, 3'd4);   // +128: out of range, R3
    do_update(16'h020B, 16'h024D, 3'd1);   // loop pair
    do_update(16'h024D, 16'h020B, 3'd2);
    wait_neg(2);
    check(hs_cnt == 0 && pf_valid == 0, "R1 no request before seed", {31'd0, pf_valid}, 0);

    // R2/R4/R5: walk the chain back to back
    expect_pf(16'h0153, 3'd2);
    expect_pf(16'h0125, 3'd1);
    expect_pf(16'h0197, 3'd3);
    do_seed(16'h0101);
    wait_neg(5);
    check(hs_cnt == 3, "R4 chain length", hs_cnt, 3);
    check(hs_last - hs_first == 2, "R4 back-to-back requests", hs_last - hs_first, 2);
    check(no_pred == 1 && pf_valid == 0, "R5 miss ends walk", {30'd0, no_pred, pf_valid}, 2);
    wait_neg(3);
    check(no_pred == 1 && hs_cnt == 3, "R5 stays stopped", hs_cnt, 3);

    // R3: out-of-range update not recorded
    do_seed(16'h0109);
    wait_neg(4);
    check(hs_cnt == 0, "R3 out-of-range key has no request", hs_cnt, 0);
    check(no_pred == 1, "R3 out-of-range key misses", {31'd0, no_pred}, 1);

    // R6: credit cap on the endless loop
    for (int i = 0; i < 2; i++) begin
      expect_pf(16'h024D, 3'd1);
      expect_pf(16'h020B, 3'd2);
    end
    do_seed(16'h020B);
    wait_neg(10);
    check(hs_cnt == 4, "R6 at most DEPTH outstanding", hs_cnt, 4);
    check(pf_valid == 0 && no_pred == 0, "R6 walk paused, not missed", {30'd0, pf_valid, no_pred}, 0);

    // R6 + R7: consume frees one slot; held while not ready
    @(posedge clk); #1 pf_ready = 0;
    do_consume();
    wait_neg(2);
    for (int i = 0; i < 3; i++) begin
      check(pf_valid == 1 && pf_addr == 16'h024D && pf_frags == 3'd1, "R7 request held while stalled",
            {13'd0, pf_addr, pf_frags}, {13'd0, 16'h024D, 3'd1});
      wait_neg(1);
    end
    check(hs_cnt == 4, "R6 consume freed exactly one", hs_cnt, 4);

    // R8: redirect drops the held request and restarts at A
    do_redirect(16'h0101);
    @(negedge clk); #1;
    check(pf_valid == 0, "R8 pending request dropped", {31'd0, pf_valid}, 0);
    expect_pf(16'h0153, 3'd2);
    expect_pf(16'h0125, 3'd1);
    expect_pf(16'h0197, 3'd3);
    @(posedge clk); #1 pf_ready = 1;
    wait_neg(8);
    check(hs_cnt == 3 && no_pred == 1, "R8 walk restarted at redirect", hs_cnt, 3);

    // R9: update and seed together, forwarding
    expect_pf(16'h0160, 3'd2);
    @(posedge clk); #1;
    hs_cnt = 0;
    upd_valid = 1; upd_key = 16'h0139; upd_target = 16'h0160; upd_frags = 3'd2;
    seed_valid = 1; seed_addr = 16'h0139;
    @(posedge clk); #1;
    upd_valid = 0; seed_valid = 0;
    wait_neg(5);
    check(hs_cnt == 1, "R9 forwarded update used by lookup", hs_cnt, 1);
    check(no_pred == 1, "R9 walk ends after forwarded hit", {31'd0, no_pred}, 1);

    // R10: aliasing replaces the entry at index 1
    do_update(16'h0311, 16'h0322, 3'd1);
    do_seed(16'h0101);
    wait_neg(4);
    check(hs_cnt == 0 && no_pred == 1, "R10 displaced key misses", hs_cnt, 0);
    expect_pf(16'h0322, 3'd1);
    do_seed(16'h0311);
    wait_neg(5);
    check(hs_cnt == 1, "R10 new key hits", hs_cnt, 1);

    check(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 0);
    finish_run();
  end

endmodule